// File: doc/BRIEF.md
# Token-Priority Split-Phase Bus Arbiter

This block decides which of three requesters drives a shared bus that runs in two alternating phases. In the arbitrate phase every requester puts an operation code and a block address on its own request inputs. The arbiter picks one winner and, in the following grant phase, broadcasts the winner's operation and address together with its master number and a one-hot grant flag. If nobody asks for the bus, it broadcasts a no-op with no master. The broadcast operation field also tells everyone which phase the bus is in: while it shows the arbitrate code, the bus is collecting requests.

Fairness comes from a rotating token that names the requester with top priority. The token moves on by one position, modulo three, at every arbitrate phase. A requester that keeps its request up is therefore served within a short, fixed number of cycles, whatever the others do. Data transfer after the grant is handled elsewhere.

The phase sequencer is a two-state machine. `PH_GRANT` is the reset state. In it the bus shows the granted operation, or no-op. `PH_ARB` shows the arbitrate code and samples the requests. The transition `PH_GRANT -> PH_ARB` is taken on every clock, and so is `PH_ARB -> PH_GRANT`.

Top module: `bus_token_arbiter`

## Requirements
- R1: Operation codes are no-op=0, read=1, xread=2, write=3, invalidate=4 and arbitrate=5. After reset `bus_op_o` is no-op. It becomes arbitrate at the first clock edge after reset is released. From then on it alternates every cycle between arbitrate and a grant-phase operation.
- R2: `master_o` encodes requesters as 0, 1 and 2, and "none" as 3. It reads 3 during reset and in every cycle in which `bus_op_o` is arbitrate.
- R3: A requester is eligible when its operation code is not 0. Request slot k occupies bits [3k+2:3k] of `req_op_i` and bits [4k+3:4k] of `req_line_i`. The search order is 0,1,2 with token 0, then 1,2,0 with token 1, then 2,0,1 with token 2. The first eligible requester in that order wins.
- R4: In the grant cycle that follows an arbitrate cycle, `bus_op_o` and `master_o` show the winner's operation and index. If there was no winner, they show no-op and 3.
- R5: `bus_line_o` takes the winner's address in the grant cycle. It keeps its previous value when there is no winner, and it keeps its value through every arbitrate cycle. It resets to 0.
- R6: The token resets to 0. It advances by one, modulo 3, only at the end of an arbitrate cycle, and it stays fixed otherwise.
- R7: `grant_o[k]` is 1 exactly when `master_o` equals k, so at most one flag is set at any time.
- R8: A requester that holds a non-zero operation code is shown as master within 6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op_i | input | 9 | Requested operation code, 3 bits per requester |
| req_line_i | input | 12 | Requested block address, 4 bits per requester |
| bus_op_o | output | 3 | Broadcast operation; the arbitrate code marks the arbitrate phase |
| bus_line_o | output | 4 | Broadcast block address |
| master_o | output | 2 | Granted requester index, 3 when no master |
| grant_o | output | 3 | One-hot grant flags decoded from the master index |

## Verification
Requests presented during an arbitrate cycle are sampled at that cycle's closing edge. Their result appears on `bus_op_o`, `master_o`, `bus_line_o` and `grant_o` exactly one cycle later, in the grant cycle. The token step made at that same edge only shows in the choice made at the next arbitrate cycle, two cycles on. The bench drives new requests just after a falling edge. A behavioural model steps with the rising edge, and all four outputs are compared with the model at the next falling edge, so each result is checked in the cycle it is due. A per-requester wait counter, kept at the same falling edges, bounds the service latency.

// File: rtl/bus_arb_pkg.sv
`timescale 1ns/1ps
package bus_arb_pkg;

    localparam int OP_W = 3;

    // Bus operation codes; BOP_ARB marks the arbitrate phase.
    typedef enum logic [OP_W-1:0] {
        BOP_NOP   = 3'd0,
        BOP_READ  = 3'd1,
        BOP_XREAD = 3'd2,
        BOP_WRITE = 3'd3,
        BOP_INVAL = 3'd4,
        BOP_ARB   = 3'd5
    } bus_op_e;

    // Phase of the split-phase bus.
    typedef enum logic {
        PH_GRANT = 1'b0,
        PH_ARB   = 1'b1
    } phase_e;

endpackage

// File: rtl/arb_token_ring.sv
`timescale 1ns/1ps
module arb_token_ring #(
    parameter int N     = 3,
    parameter int TOK_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [TOK_W-1:0] token_o
);

    localparam logic [TOK_W-1:0] TOK_LAST = TOK_W'(N - 1);

    logic [TOK_W-1:0] tok_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q <= '0;
        end else if (adv_i) begin
            tok_q <= (tok_q == TOK_LAST) ? '0 : tok_q + TOK_W'(1);
        end
    end

    assign token_o = tok_q;

    AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(tok_q)); // R6

    AST_TOKEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_q <= TOK_LAST); // R6

endmodule

// File: rtl/arb_rot_pick.sv
`timescale 1ns/1ps
module arb_rot_pick #(
    parameter int N     = 3,
    parameter int TOK_W = (N > 1) ? $clog2(N) : 1,
    parameter int MST_W = $clog2(N + 1)
) (
    input  logic [TOK_W-1:0] token_i,
    input  logic [N-1:0]     elig_i,
    output logic             win_valid_o,
    output logic [MST_W-1:0] win_idx_o
);

    // Walk the requesters starting at the token holder; first eligible wins.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = MST_W'(N);
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(token_i) + k;
            if (idx >= N) begin
                idx = idx - N;
            end
            if (!win_valid_o && elig_i[idx]) begin
                win_valid_o = 1'b1;
                win_idx_o   = MST_W'(idx);
            end
        end
    end

endmodule

// File: rtl/arb_phase_fsm.sv
`timescale 1ns/1ps
module arb_phase_fsm
    import bus_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic arb_o
);

    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_GRANT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_GRANT: state_d = PH_ARB;
            PH_ARB:   state_d = PH_GRANT;
            default:  state_d = PH_GRANT;
        endcase
    end

    assign arb_o = (state_q == PH_ARB);

    AST_FSM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        arb_o |=> !arb_o); // R1

endmodule

// File: rtl/bus_token_arbiter.sv
`timescale 1ns/1ps
module bus_token_arbiter
    import bus_arb_pkg::*;
#(
    parameter int NUM_REQ = 3,
    parameter int LINE_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_REQ*OP_W-1:0]     req_op_i,
    input  logic [NUM_REQ*LINE_W-1:0]   req_line_i,
    output logic [OP_W-1:0]             bus_op_o,
    output logic [LINE_W-1:0]           bus_line_o,
    output logic [$clog2(NUM_REQ+1)-1:0] master_o,
    output logic [NUM_REQ-1:0]          grant_o
);

    localparam int TOK_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam int MST_W = $clog2(NUM_REQ + 1);
    localparam logic [MST_W-1:0] MST_NONE = MST_W'(NUM_REQ);

    logic               arb;
    logic [TOK_W-1:0]   token;
    logic [NUM_REQ-1:0] elig;
    logic               win_valid;
    logic [MST_W-1:0]   win_idx;
    logic [OP_W-1:0]    sel_op;
    logic [LINE_W-1:0]  sel_line;

    logic [OP_W-1:0]    gop_q;
    logic [MST_W-1:0]   mst_q;
    logic [LINE_W-1:0]  line_q;

    arb_phase_fsm u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .arb_o (arb)
    );

    arb_token_ring #(.N(NUM_REQ), .TOK_W(TOK_W)) u_token (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (arb),
        .token_o (token)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_REQ; g++) begin : g_req
            assign elig[g]    = (req_op_i[g*OP_W +: OP_W] != BOP_NOP);
            assign grant_o[g] = (mst_q == MST_W'(g));
        end
    endgenerate

    arb_rot_pick #(.N(NUM_REQ), .TOK_W(TOK_W), .MST_W(MST_W)) u_pick (
        .token_i     (token),
        .elig_i      (elig),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx)
    );

    always_comb begin
        sel_op   = BOP_NOP;
        sel_line = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (win_idx == MST_W'(i)) begin
                sel_op   = req_op_i[i*OP_W +: OP_W];
                sel_line = req_line_i[i*LINE_W +: LINE_W];
            end
        end
    end

    // Grant-phase registers, loaded from the arbitrate cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gop_q  <= BOP_NOP;
            mst_q  <= MST_NONE;
            line_q <= '0;
        end else if (arb) begin
            gop_q <= win_valid ? sel_op : BOP_NOP;
            mst_q <= win_valid ? win_idx : MST_NONE;
            if (win_valid) begin
                line_q <= sel_line;
            end
        end else begin
            mst_q <= MST_NONE;
        end
    end

    assign bus_op_o   = arb ? BOP_ARB : gop_q;
    assign bus_line_o = line_q;
    assign master_o   = mst_q;

    AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op_o == BOP_ARB) |=> (bus_op_o != BOP_ARB)); // R1

    AST_PHASE_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op_o != BOP_ARB) |=> (bus_op_o == BOP_ARB)); // R1

    AST_ARB_NO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op_o == BOP_ARB) |-> (master_o == MST_NONE)); // R2

    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> elig[win_idx]); // R3

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op_o == BOP_NOP) |-> (grant_o == '0)); // R4

    AST_LINE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op_o == BOP_ARB) |-> $stable(bus_line_o)); // R5

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R7

endmodule

// File: tb/bus_token_arbiter_bench.sv
`timescale 1ns/1ps
module bus_token_arbiter_bench;

    localparam int N  = 3;
    localparam int OW = 3;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N*OW-1:0] req_op = '0;
    logic [N*LW-1:0] req_line = '0;
    logic [OW-1:0] bus_op;
    logic [LW-1:0] bus_line;
    logic [1:0]    master;
    logic [N-1:0]  grant;

    bus_token_arbiter u_bus_token_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_op_i   (req_op),
        .req_line_i (req_line),
        .bus_op_o   (bus_op),
        .bus_line_o (bus_line),
        .master_o   (master),
        .grant_o    (grant)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int m_op, m_master, m_line, m_token;
    int n_op, n_master, n_line, n_token;
    int wait_c[N];
    int max_wait = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_grant();
        return (m_master == 3) ? 0 : (1 << m_master);
    endfunction

    function automatic logic [N*OW-1:0] ops(int a, int b, int c);
        return {c[2:0], b[2:0], a[2:0]};
    endfunction

    task automatic compare_all();
        chk("R1 R4 bus_op", int'(bus_op), m_op);
        chk("R2 R3 R6 master", int'(master), m_master);
        chk("R5 bus_line", int'(bus_line), m_line);
        chk("R7 grant", int'(grant), exp_grant());
        for (int i = 0; i < N; i++) begin
            if (req_op[i*OW +: OW] != 0 && int'(master) != i) wait_c[i]++;
            else wait_c[i] = 0;
            if (wait_c[i] > max_wait) max_wait = wait_c[i];
        end
    endtask

    task automatic model_next();
        if (m_op != 5) begin
            n_op = 5; n_master = 3; n_line = m_line; n_token = m_token;
        end else begin
            int win;
            win = 3;
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = (m_token + k) % N;
                if (win == 3 && req_op[idx*OW +: OW] != 0) win = idx;
            end
            if (win != 3) begin
                n_op = int'(req_op[win*OW +: OW]);
                n_line = int'(req_line[win*LW +: LW]);
            end else begin
                n_op = 0;
                n_line = m_line;
            end
            n_master = win;
            n_token = (m_token + 1) % N;
        end
    endtask

    task automatic apply();
        m_op = n_op; m_master = n_master; m_line = n_line; m_token = n_token;
    endtask

    task automatic step(logic [N*OW-1:0] op, logic [N*LW-1:0] ln);
        @(negedge clk);
        compare_all();
        req_op = op;
        req_line = ln;
        model_next();
        @(posedge clk);
        apply();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        m_op = 0; m_master = 3; m_line = 0; m_token = 0;
        for (int i = 0; i < N; i++) wait_c[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: R1 no-op, R2 no master, R5 line zero, R7 no grant
        compare_all();
        rst_n = 1'b1;
        model_next();
        @(posedge clk);
        apply();

        // R4: no requests, grant phase stays no-op with no master
        repeat (4) step('0, '0);

        // R3 R4 R5: each requester alone
        for (int r = 0; r < N; r++) begin
            logic [N*OW-1:0] o;
            o = '0;
            o[r*OW +: OW] = 3'(r + 1);
            repeat (4) step(o, {4'hC, 4'h7, 4'h3} ^ 12'(r * 273));
        end

        // R5: requests drop, line keeps last winner's address
        repeat (4) step('0, 12'hFFF);

        // R3 R6 R8: all persistent, token rotation decides the order
        repeat (14) step(ops(1, 2, 3), 12'h951);

        // R3: requesters 0 and 2 only
        repeat (8) step(ops(4, 0, 3), 12'hA2B);

        // Random traffic
        for (int t = 0; t < 400; t++) begin
            step(ops($urandom_range(4, 0), $urandom_range(4, 0), $urandom_range(4, 0)),
                 12'($urandom));
        end

        repeat (2) step('0, '0);
        chk("R8 max wait within 6", (max_wait <= 6) ? 1 : 0, 1);
        finish_run();
    end

endmodule